// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column addresses of one read or write burst to a synchronous DRAM, one per clock. A single-cycle start request loads a starting column, a 3-bit burst length code and an ordering select. From the next cycle the block drives one column address per cycle with a valid strobe, and it raises a last flag on the final beat. Only the low column bits inside the aligned burst window change. The bits above the window keep the value loaded at the start.

Two orderings can be chosen for each burst. In sequential order the low bits count up from the start offset and wrap back to the base of the aligned block. In interleaved order, beat n uses the start offset XOR n. A command sequencer uses the block by pulsing the start input while `busy` is low and then issuing one column command for each beat that has the valid strobe.

Top module: `burst_col_seq`

## Requirements
- R1: While reset (`rstN` low) is held, and after it is released with no start, `beatValid`, `beatLast` and `busy` are low.
- R2: A start request sampled while `busy` is low begins a burst. On the next cycle `beatValid` is high and `colOut` equals the loaded start column.
- R3: Length code 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats. Every other code gives a burst of exactly one beat.
- R4: When `interleave` is 0 (sequential), the window bits of beat n are (start offset + n) modulo the burst length. For example, length 4 from offset 2 gives 2, 3, 0, 1.
- R5: When `interleave` is 1, the window bits of beat n are the start offset XOR n. For example, length 8 from offset 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R6: The window is bit 0 for length 2, bits 1..0 for length 4 and bits 2..0 for length 8. Every column bit outside the window keeps its loaded value on every beat. A single-beat access outputs the whole start column.
- R7: Beats are emitted on consecutive cycles with no gaps. `beatLast` is high on beat (length − 1) and on no other beat, and never while `beatValid` is low.
- R8: A start request sampled while `busy` is high is ignored, including on the last beat. `busy` stays high from the first beat through the last beat.
- R9: With a start offset of zero, both orderings give the same plain ascending order.
- R10: After the last beat, `busy` is low on the next cycle, and a new start request is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Single-cycle request to begin a burst |
| startCol | input | COL_W | Starting column address |
| lenCode | input | LEN_W | Burst length code (1→2, 2→4, 3→8, else single beat) |
| interleave | input | 1 | Ordering select: 0 sequential, 1 interleaved |
| colOut | output | COL_W | Column address of the current beat |
| beatValid | output | 1 | High on each beat of a burst |
| beatLast | output | 1 | High on the final beat |
| busy | output | 1 | High while a burst is in progress |

## Verification
The bench drives start offsets that sit in the middle of the window. If the modulo wrap were missing, a sequential burst would carry into the upper column bits. If the XOR were swapped for an add, an interleaved burst would give the sequential order. Reserved length codes 0, 4 and 7 are applied: a faulty decode would stretch these into multi-beat bursts or emit no beat at all. A start request is held high across a whole burst, including its last beat. A design that accepted it would restart or extend the burst, and the scoreboard would report the extra beats. Bursts are also issued back to back, so a last flag one beat off or a `busy` that drops late appears as a mismatch or a lost burst.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new burst
    logic step;   // advance to the next beat
  } seqCtrl_t;

endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
  import bseq_pkg::*;
#(
  parameter int LEN_W   = 3,
  parameter int MAX_LOG = 3,
  localparam int IDX_W  = MAX_LOG,
  localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [LEN_W-1:0] lenCode,
  output seqCtrl_t         ctrl,
  output logic [IDX_W-1:0] beatIdx,
  output logic [LOG_W-1:0] winLog,
  output logic             active,
  output logic             isLast
);

  logic             accept;
  logic [LOG_W-1:0] winLogDec;
  logic [IDX_W-1:0] lastIdx;

  // Requests are taken only while idle
  assign accept = startReq && !active;

  // Length decode: codes 1..MAX_LOG give a window of that many bits, others one beat
  always_comb begin
    winLogDec = '0;
    if (lenCode != '0 && lenCode <= LEN_W'(MAX_LOG))
      winLogDec = LOG_W'(lenCode);
  end

  // Final beat index is all ones across the window
  for (genvar b = 0; b < IDX_W; b++) begin : g_last
    assign lastIdx[b] = (winLog > LOG_W'(b));
  end

  assign isLast    = active && (beatIdx == lastIdx);
  assign ctrl.load = accept;
  assign ctrl.step = active && !isLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      beatIdx <= '0;
      winLog  <= '0;
    end else if (accept) begin
      active  <= 1'b1;
      beatIdx <= '0;
      winLog  <= winLogDec;
    end else if (active) begin
      if (isLast) active <= 1'b0;
      else        beatIdx <= beatIdx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/bseq_datapath.sv
module bseq_datapath
  import bseq_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int MAX_LOG = 3,
  localparam int IDX_W  = MAX_LOG,
  localparam int LOG_W  = $clog2(MAX_LOG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqCtrl_t         ctrl,
  input  logic [COL_W-1:0] startCol,
  input  logic             interleave,
  input  logic [IDX_W-1:0] beatIdx,
  input  logic [LOG_W-1:0] winLog,
  output logic [COL_W-1:0] colOut
);

  logic [COL_W-1:0] baseQ;
  logic             modeQ;
  logic [IDX_W-1:0] nextIdx;
  logic [IDX_W-1:0] seqLow;
  logic [IDX_W-1:0] xorLow;
  logic [IDX_W-1:0] pickLow;
  logic [IDX_W-1:0] winMask;
  logic [COL_W-1:0] nextCol;

  assign nextIdx = beatIdx + IDX_W'(1);
  assign seqLow  = baseQ[IDX_W-1:0] + nextIdx;
  assign xorLow  = baseQ[IDX_W-1:0] ^ nextIdx;
  assign pickLow = modeQ ? xorLow : seqLow;

  for (genvar b = 0; b < COL_W; b++) begin : g_col
    if (b < IDX_W) begin : g_win
      assign winMask[b] = (winLog > LOG_W'(b));
      assign nextCol[b] = winMask[b] ? pickLow[b] : baseQ[b];
    end else begin : g_up
      assign nextCol[b] = baseQ[b];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      modeQ  <= 1'b0;
      colOut <= '0;
    end else if (ctrl.load) begin
      baseQ  <= startCol;
      modeQ  <= interleave;
      colOut <= startCol;
    end else if (ctrl.step) begin
      colOut <= nextCol;
    end
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bseq_pkg::*;
#(
  parameter int COL_W   = 10,
  parameter int LEN_W   = 3,
  parameter int MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleave,
  output logic [COL_W-1:0] colOut,
  output logic             beatValid,
  output logic             beatLast,
  output logic             busy
);

  localparam int IDX_W = MAX_LOG;
  localparam int LOG_W = $clog2(MAX_LOG + 1);

  seqCtrl_t         ctrl;
  logic [IDX_W-1:0] beatIdx;
  logic [LOG_W-1:0] winLog;
  logic             active;
  logic             isLast;

  bseq_ctrl #(.LEN_W(LEN_W), .MAX_LOG(MAX_LOG)) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lenCode(lenCode),
    .ctrl(ctrl), .beatIdx(beatIdx), .winLog(winLog),
    .active(active), .isLast(isLast)
  );

  bseq_datapath #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .startCol(startCol),
    .interleave(interleave), .beatIdx(beatIdx), .winLog(winLog),
    .colOut(colOut)
  );

  assign beatValid = active;
  assign beatLast  = isLast;
  assign busy      = active;

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int COL_W   = 10,
  parameter int LEN_W   = 3,
  parameter int MAX_LOG = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [COL_W-1:0] startCol,
  input logic [LEN_W-1:0] lenCode,
  input logic             interleave,
  input logic [COL_W-1:0] colOut,
  input logic             beatValid,
  input logic             beatLast,
  input logic             busy
);

  logic unusedMode;
  assign unusedMode = interleave;

  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (beatValid && colOut == $past(startCol)));

  // R3
  single_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy && (lenCode == '0 || lenCode > LEN_W'(MAX_LOG))) |=> beatLast);

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatLast) |=> (colOut[COL_W-1:MAX_LOG] == $past(colOut[COL_W-1:MAX_LOG])));

  // R7
  last_in_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatLast |-> beatValid);

  // R8
  no_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatLast) |=> (beatValid && busy));

  // R10
  idle_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    beatLast |=> !busy);

endmodule

bind burst_col_seq bseq_chk #(.COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG(MAX_LOG)) i_chk (.*);

// File: tb/test_burst_col_seq.sv
`timescale 1ns/1ps
module test_burst_col_seq;

  localparam int COL_W = 10;
  localparam int LEN_W = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             startReq = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [LEN_W-1:0] lenCode = '0;
  logic             interleave = 1'b0;
  logic [COL_W-1:0] colOut;
  logic             beatValid, beatLast, busy;

  int total = 0;
  int bad = 0;

  logic [COL_W-1:0] expCol[$];
  logic             expLast[$];
  string            expReq[$];

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W), .LEN_W(LEN_W), .MAX_LOG(3)) i_burst_col_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startCol(startCol),
    .lenCode(lenCode), .interleave(interleave), .colOut(colOut),
    .beatValid(beatValid), .beatLast(beatLast), .busy(busy)
  );

  function automatic int beatsOf(input logic [LEN_W-1:0] code);
    case (code)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [COL_W-1:0] colFor(input logic [COL_W-1:0] s,
      input logic [LEN_W-1:0] code, input logic ilv, input int n);
    int len, off, lo;
    len = beatsOf(code);
    off = int'(s) % len;
    lo  = ilv ? (off ^ n) : ((off + n) % len);
    return COL_W'(int'(s) - off + lo);
  endfunction

  task automatic check(input string req, input logic ok, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Driver: pushes expectations and pulses start for one cycle
  task automatic startBurst(input logic [COL_W-1:0] s, input logic [LEN_W-1:0] code,
      input logic ilv, input string req);
    @(negedge clk);
    while (busy) @(negedge clk);
    for (int n = 0; n < beatsOf(code); n++) begin
      expCol.push_back(colFor(s, code, ilv, n));
      expLast.push_back(n == beatsOf(code) - 1);
      expReq.push_back(req);
    end
    startReq = 1'b1; startCol = s; lenCode = code; interleave = ilv;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((expCol.size() != 0 || busy) && guard < 100) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Monitor: compare each beat against the scoreboard
  always @(negedge clk) begin
    if (rstN && beatValid) begin
      if (expCol.size() == 0) begin
        check("R8", 1'b0, int'(colOut), -1);
      end else begin
        automatic logic [COL_W-1:0] c = expCol.pop_front();
        automatic logic             l = expLast.pop_front();
        automatic string            r = expReq.pop_front();
        check(r, colOut == c, int'(colOut), int'(c));
        check("R7", beatLast == l, int'(beatLast), int'(l));
        check("R8", busy == 1'b1, int'(busy), 1);
      end
    end else if (rstN) begin
      check("R7", beatLast == 1'b0, int'(beatLast), 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog", 1'b0, 0, 1);
    finishUp();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {beatValid, beatLast, busy} == 3'b000, int'({beatValid, beatLast, busy}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {beatValid, beatLast, busy} == 3'b000, int'({beatValid, beatLast, busy}), 0);

    // R4, R6: sequential wrap with upper bits held
    startBurst(10'h1A2, 3'd2, 1'b0, "R4");
    startBurst(10'h2F3, 3'd3, 1'b0, "R4");
    startBurst(10'h0C1, 3'd1, 1'b0, "R6");
    // R5: interleaved
    startBurst(10'h305, 3'd3, 1'b1, "R5");
    startBurst(10'h0B3, 3'd2, 1'b1, "R5");
    startBurst(10'h3FF, 3'd1, 1'b1, "R5");
    // R9: zero offset, both orderings
    startBurst(10'h148, 3'd3, 1'b0, "R9");
    startBurst(10'h148, 3'd3, 1'b1, "R9");
    // R3: reserved codes give single beats, whole address kept (R6)
    startBurst(10'h2A7, 3'd0, 1'b0, "R3");
    startBurst(10'h155, 3'd4, 1'b1, "R3");
    startBurst(10'h0E6, 3'd7, 1'b0, "R3");
    // R2, R10: back-to-back bursts
    startBurst(10'h011, 3'd1, 1'b0, "R10");
    startBurst(10'h3C6, 3'd2, 1'b1, "R10");
    drain();

    // R8: start held high across a whole burst, including its last beat
    startBurst(10'h21D, 3'd3, 1'b0, "R8");
    startReq = 1'b1; startCol = 10'h000; lenCode = 3'd2; interleave = 1'b1;
    for (int k = 0; k < 8; k++) @(negedge clk);
    startReq = 1'b0;
    repeat (4) @(negedge clk);
    check("R8", busy == 1'b0, int'(busy), 0);
    check("R8", expCol.size() == 0, expCol.size(), 0);

    drain();
    check("R10", expCol.size() == 0 && !busy, expCol.size(), 0);
    finishUp();
  end

endmodule